// File: doc/BRIEF.md
# Reference Clock Frequency Limit Checker

This block measures how fast an external reference clock runs against a trusted local reference. A measurement window is opened and closed in the local-reference domain. Its length is a programmed number of local-reference cycles. While the window is open, a second counter in the external-reference domain counts external cycles. When the window closes, the external count is returned to the register clock domain and compared with a programmed lower and upper limit. The result is a done flag, a pass flag and the count itself.

Software writes the window length and both limits into staging registers at any time. A new measurement copies the staging values into an active set. Writes made during a measurement therefore only affect the next one. Three clock domains are involved: the register clock, the local reference and the external reference. The window gate crosses from the local domain to the external domain as a toggle. The end of counting comes back the same way, and the count is picked up only after that toggle has been seen. The register clock also times out a measurement whose external clock never answers. A separate select input chooses which of the two references is driven out towards the output connector.

Top module: `refclk_freq_check`

## Requirements
- R1: After reset, busy, done and pass are 0 and ext_count is 0.
- R2: A start pulse while busy is 0 makes busy 1 on the next register clock edge and clears done. A start pulse while busy is 1 is ignored: it neither restarts the window nor reloads the staged settings.
- R3: The window lasts exactly the active end count of local-reference cycles; an end count of 0 acts as 1. With the external clock at the same frequency as the local one, ext_count equals the end count.
- R4: ext_count follows the external frequency: it is the number of external cycles in the window, within one count.
- R5: pass is 1 only when lo_limit <= ext_count <= hi_limit, with both bounds inclusive, and is 0 otherwise.
- R6: done rises together with the final pass and ext_count. done is never 1 while busy is 1. It stays 1 until clear or the next accepted start.
- R7: wr_end, wr_lo and wr_hi load wr_data into staging registers at any time. An accepted start copies the staging values into the active set, so writes during a measurement do not change its result.
- R8: If no end-of-count answer comes from the external domain within TMO_CYC register clock cycles after the window closes, the measurement ends with ext_count 0. A result with ext_count 0 always has pass 0.
- R9: clear sets done, pass and ext_count to 0 on the next edge. A clear during a measurement discards that measurement: busy falls when the measurement completes, and done stays 0.
- R10: ref_out carries clk_ext when ref_sel is 1 and clk_loc when ref_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_loc | input | 1 | Local reference clock, defines the window |
| clk_ext | input | 1 | External reference clock under test |
| ref_sel | input | 1 | 1 routes clk_ext to ref_out, 0 routes clk_loc |
| ref_out | output | 1 | Selected reference clock |
| wr_data | input | W | Data for the staging writes |
| wr_end | input | 1 | Write wr_data to the staged window length |
| wr_lo | input | 1 | Write wr_data to the staged lower limit |
| wr_hi | input | 1 | Write wr_data to the staged upper limit |
| start | input | 1 | Start a measurement (one-cycle pulse) |
| clear | input | 1 | Clear the result, abort a running measurement |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | External count lies within the limits |
| ext_count | output | W | External cycles counted in the last window |

## Verification
The count path is first tried with the external clock at the same frequency as the local one. This gives an exact count and allows limits of exactly that count, or one above or one below it. Those runs tell inclusive bounds from exclusive ones. The external clock is then run faster and slower. This shows the count really comes from the external domain and is not copied from the window length. Staged values are rewritten during a measurement, along with a second start and a mid-run clear. This tells double buffering apart from direct use of the written values. Finally, the external clock is stopped to show the timeout ends the measurement with a zero count and a fail.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_CLOSE = 2'd2,
    ST_EXT   = 2'd3
  } rfc_state_e;
endpackage

// File: rtl/rfc_sync.sv
`timescale 1ns/1ps
module rfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rfc_rst_sync.sv
`timescale 1ns/1ps
module rfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/rfc_loc_window.sv
`timescale 1ns/1ps
module rfc_loc_window #(
  parameter int W = 16
) (
  input  logic         clk_loc,
  input  logic         rst_n,
  input  logic         start_s,
  input  logic [W-1:0] end_cnt,
  output logic         gate_tgl,
  output logic         win_open
);
  logic         start_p_q, start_p_n;
  logic         open_q, open_n;
  logic         tgl_q, tgl_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] last_cnt;
  logic         start_edge;

  assign last_cnt   = (end_cnt == '0) ? '0 : end_cnt - 1'b1;
  assign start_edge = start_s ^ start_p_q;

  always_comb begin
    start_p_n = start_s;
    open_n    = open_q;
    tgl_n     = tgl_q;
    cnt_n     = cnt_q;
    if (start_edge && !open_q) begin
      open_n = 1'b1;
      cnt_n  = '0;
      tgl_n  = ~tgl_q;
    end else if (open_q) begin
      if (cnt_q >= last_cnt) begin
        open_n = 1'b0;
        tgl_n  = ~tgl_q;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      start_p_q <= 1'b0;
      open_q    <= 1'b0;
      tgl_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      start_p_q <= start_p_n;
      open_q    <= open_n;
      tgl_q     <= tgl_n;
      cnt_q     <= cnt_n;
    end
  end

  assign gate_tgl = tgl_q;
  assign win_open = open_q;
endmodule

// File: rtl/rfc_ext_counter.sv
`timescale 1ns/1ps
module rfc_ext_counter #(
  parameter int W = 16
) (
  input  logic         clk_ext,
  input  logic         rst_n,
  input  logic         gate_s,
  output logic [W-1:0] ext_cnt,
  output logic         done_tgl
);
  logic         gate_p_q, gate_p_n;
  logic         on_q, on_n;
  logic         dt_q, dt_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] cnt_inc;
  logic         gate_edge;

  assign gate_edge = gate_s ^ gate_p_q;
  assign cnt_inc   = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    gate_p_n = gate_s;
    on_n     = on_q;
    dt_n     = dt_q;
    cnt_n    = cnt_q;
    if (gate_edge && !on_q) begin
      on_n  = 1'b1;
      cnt_n = '0;
    end else if (gate_edge && on_q) begin
      on_n  = 1'b0;
      dt_n  = ~dt_q;
      cnt_n = cnt_inc;
    end else if (on_q) begin
      cnt_n = cnt_inc;
    end
  end

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      gate_p_q <= 1'b0;
      on_q     <= 1'b0;
      dt_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      gate_p_q <= gate_p_n;
      on_q     <= on_n;
      dt_q     <= dt_n;
      cnt_q    <= cnt_n;
    end
  end

  assign ext_cnt  = cnt_q;
  assign done_tgl = dt_q;
endmodule

// File: rtl/rfc_ctrl.sv
`timescale 1ns/1ps
module rfc_ctrl
  import rfc_pkg::*;
#(
  parameter int W       = 16,
  parameter int TMO_CYC = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  input  logic         wr_end,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         start,
  input  logic         clear,
  input  logic         gate_s,
  input  logic         done_s,
  input  logic [W-1:0] ext_cnt,
  output logic         start_tgl,
  output logic [W-1:0] act_end,
  output logic [W-1:0] act_lo,
  output logic [W-1:0] act_hi,
  output logic         busy,
  output logic         done,
  output logic         pass,
  output logic [W-1:0] count
);
  localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  rfc_state_e   st_q, st_n;
  logic [W-1:0] stg_end_q, stg_end_n, stg_lo_q, stg_lo_n, stg_hi_q, stg_hi_n;
  logic [W-1:0] act_end_q, act_end_n, act_lo_q, act_lo_n, act_hi_q, act_hi_n;
  logic [W-1:0] cap_q, cap_n, cnt_q, cnt_n;
  logic [TW-1:0] tmo_q, tmo_n;
  logic         tgl_q, tgl_n, got_q, got_n, abort_q, abort_n;
  logic         done_q, done_n, pass_q, pass_n;
  logic         gate_p_q, done_p_q;
  logic         gate_edge, done_edge, finish;
  logic [W-1:0] fin_cnt;

  assign gate_edge = gate_s ^ gate_p_q;
  assign done_edge = done_s ^ done_p_q;

  always_comb begin
    st_n      = st_q;
    stg_end_n = wr_end ? wr_data : stg_end_q;
    stg_lo_n  = wr_lo  ? wr_data : stg_lo_q;
    stg_hi_n  = wr_hi  ? wr_data : stg_hi_q;
    act_end_n = act_end_q;
    act_lo_n  = act_lo_q;
    act_hi_n  = act_hi_q;
    cap_n     = cap_q;
    cnt_n     = cnt_q;
    tmo_n     = tmo_q;
    tgl_n     = tgl_q;
    got_n     = got_q;
    abort_n   = abort_q;
    done_n    = done_q;
    pass_n    = pass_q;
    finish    = 1'b0;
    fin_cnt   = '0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          act_end_n = stg_end_q;
          act_lo_n  = stg_lo_q;
          act_hi_n  = stg_hi_q;
          tgl_n     = ~tgl_q;
          done_n    = 1'b0;
          pass_n    = 1'b0;
          cnt_n     = '0;
          abort_n   = 1'b0;
          got_n     = 1'b0;
          st_n      = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (gate_edge) st_n = ST_CLOSE;
      end
      ST_CLOSE: begin
        if (done_edge) begin
          got_n = 1'b1;
          cap_n = ext_cnt;
        end
        if (gate_edge) begin
          st_n  = ST_EXT;
          tmo_n = '0;
        end
      end
      default: begin
        if (got_q || done_edge) begin
          finish  = 1'b1;
          fin_cnt = done_edge ? ext_cnt : cap_q;
        end else if (tmo_q == TMO_LAST) begin
          finish  = 1'b1;
          fin_cnt = '0;
        end else begin
          tmo_n = tmo_q + 1'b1;
        end
      end
    endcase
    if (finish) begin
      st_n = ST_IDLE;
      if (!abort_q && !clear) begin
        done_n = 1'b1;
        cnt_n  = fin_cnt;
        pass_n = (fin_cnt != '0) && (fin_cnt >= act_lo_q) && (fin_cnt <= act_hi_q);
      end
    end
    if (clear) begin
      done_n = 1'b0;
      pass_n = 1'b0;
      cnt_n  = '0;
      if (st_q != ST_IDLE && !finish) abort_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      stg_end_q <= '0;
      stg_lo_q  <= '0;
      stg_hi_q  <= '1;
      act_end_q <= '0;
      act_lo_q  <= '0;
      act_hi_q  <= '1;
      cap_q     <= '0;
      cnt_q     <= '0;
      tmo_q     <= '0;
      tgl_q     <= 1'b0;
      got_q     <= 1'b0;
      abort_q   <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      gate_p_q  <= 1'b0;
      done_p_q  <= 1'b0;
    end else begin
      st_q      <= st_n;
      stg_end_q <= stg_end_n;
      stg_lo_q  <= stg_lo_n;
      stg_hi_q  <= stg_hi_n;
      act_end_q <= act_end_n;
      act_lo_q  <= act_lo_n;
      act_hi_q  <= act_hi_n;
      cap_q     <= cap_n;
      cnt_q     <= cnt_n;
      tmo_q     <= tmo_n;
      tgl_q     <= tgl_n;
      got_q     <= got_n;
      abort_q   <= abort_n;
      done_q    <= done_n;
      pass_q    <= pass_n;
      gate_p_q  <= gate_s;
      done_p_q  <= done_s;
    end
  end

  assign start_tgl = tgl_q;
  assign act_end   = act_end_q;
  assign act_lo    = act_lo_q;
  assign act_hi    = act_hi_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign pass      = pass_q;
  assign count     = cnt_q;
endmodule

// File: rtl/refclk_freq_check.sv
`timescale 1ns/1ps
module refclk_freq_check #(
  parameter int W       = 16,
  parameter int TMO_CYC = 256,
  parameter int SYNC_N  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_loc,
  input  logic         clk_ext,
  input  logic         ref_sel,
  output logic         ref_out,
  input  logic [W-1:0] wr_data,
  input  logic         wr_end,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         start,
  input  logic         clear,
  output logic         busy,
  output logic         done,
  output logic         pass,
  output logic [W-1:0] ext_count
);
  localparam int N_DOM = 3;

  logic [N_DOM-1:0] dom_clk;
  logic [N_DOM-1:0] dom_rst_n;
  logic             rst_n_reg, rst_n_loc, rst_n_ext;
  logic             start_tgl, start_s_loc;
  logic             gate_tgl, gate_s_ext, gate_s_reg;
  logic             done_tgl, done_s_reg;
  logic             win_open;
  logic [W-1:0]     act_end, act_lo, act_hi, ext_cnt;

  assign dom_clk = {clk_ext, clk_loc, clk};

  for (genvar g = 0; g < N_DOM; g++) begin : g_rst
    rfc_rst_sync #(.STAGES(SYNC_N)) u_rst (
      .clk        (dom_clk[g]),
      .rst_n      (rst_n),
      .rst_n_sync (dom_rst_n[g])
    );
  end

  assign rst_n_reg = dom_rst_n[0];
  assign rst_n_loc = dom_rst_n[1];
  assign rst_n_ext = dom_rst_n[2];

  rfc_ctrl #(.W(W), .TMO_CYC(TMO_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_reg),
    .wr_data   (wr_data),
    .wr_end    (wr_end),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .start     (start),
    .clear     (clear),
    .gate_s    (gate_s_reg),
    .done_s    (done_s_reg),
    .ext_cnt   (ext_cnt),
    .start_tgl (start_tgl),
    .act_end   (act_end),
    .act_lo    (act_lo),
    .act_hi    (act_hi),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .count     (ext_count)
  );

  rfc_sync #(.STAGES(SYNC_N)) u_sync_start (
    .clk (clk_loc), .rst_n (rst_n_loc), .d (start_tgl), .q (start_s_loc)
  );

  rfc_loc_window #(.W(W)) u_win (
    .clk_loc  (clk_loc),
    .rst_n    (rst_n_loc),
    .start_s  (start_s_loc),
    .end_cnt  (act_end),
    .gate_tgl (gate_tgl),
    .win_open (win_open)
  );

  rfc_sync #(.STAGES(SYNC_N)) u_sync_gate_ext (
    .clk (clk_ext), .rst_n (rst_n_ext), .d (gate_tgl), .q (gate_s_ext)
  );

  rfc_sync #(.STAGES(SYNC_N)) u_sync_gate_reg (
    .clk (clk), .rst_n (rst_n_reg), .d (gate_tgl), .q (gate_s_reg)
  );

  rfc_ext_counter #(.W(W)) u_ext (
    .clk_ext  (clk_ext),
    .rst_n    (rst_n_ext),
    .gate_s   (gate_s_ext),
    .ext_cnt  (ext_cnt),
    .done_tgl (done_tgl)
  );

  rfc_sync #(.STAGES(SYNC_N)) u_sync_done (
    .clk (clk), .rst_n (rst_n_reg), .d (done_tgl), .q (done_s_reg)
  );

  assign ref_out = ref_sel ? clk_ext : clk_loc;
endmodule

// File: rtl/rfc_chk.sv
`timescale 1ns/1ps
module rfc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         clear,
  input logic         busy,
  input logic         done,
  input logic         pass,
  input logic [W-1:0] ext_count,
  input logic [W-1:0] act_lo,
  input logic [W-1:0] act_hi,
  input logic         win_open
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear && !start) |=> done); // R6

  AST_PASS_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (ext_count >= act_lo && ext_count <= act_hi)); // R5

  AST_OUT_OF_LIMITS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ext_count < act_lo || ext_count > act_hi)) |-> !pass); // R5

  AST_ZERO_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ext_count == '0) |-> !pass); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!done && !pass && ext_count == '0)); // R9

  AST_IDLE_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !(done && win_open)); // R6
endmodule

bind refclk_freq_check rfc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .clear     (clear),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .ext_count (ext_count),
  .act_lo    (act_lo),
  .act_hi    (act_hi),
  .win_open  (win_open)
);

// File: tb/sim_refclk_freq_check.sv
`timescale 1ns/1ps
module sim_refclk_freq_check;
  localparam int W = 16;

  logic         clk, rst_n, clk_loc, clk_ext, ref_sel, ref_out;
  logic [W-1:0] wr_data;
  logic         wr_end, wr_lo, wr_hi, start, clear;
  logic         busy, done, pass;
  logic [W-1:0] ext_count;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ext_en = 1'b1;
  real ext_half = 50.0;

  refclk_freq_check #(.W(W)) u0 (
    .clk (clk), .rst_n (rst_n), .clk_loc (clk_loc), .clk_ext (clk_ext),
    .ref_sel (ref_sel), .ref_out (ref_out), .wr_data (wr_data),
    .wr_end (wr_end), .wr_lo (wr_lo), .wr_hi (wr_hi), .start (start),
    .clear (clear), .busy (busy), .done (done), .pass (pass),
    .ext_count (ext_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial clk_loc = 1'b0;
  always #50 clk_loc = ~clk_loc;

  initial begin
    clk_ext = 1'b0;
    #37;
    forever begin
      #(ext_half);
      if (ext_en) clk_ext = ~clk_ext;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int which, input logic [W-1:0] val);
    @(negedge clk);
    wr_data = val;
    wr_end  = (which == 0);
    wr_lo   = (which == 1);
    wr_hi   = (which == 2);
    @(negedge clk);
    wr_end = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic set_all(input logic [W-1:0] e, input logic [W-1:0] lo, input logic [W-1:0] hi);
    write_reg(0, e);
    write_reg(1, lo);
    write_reg(2, hi);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic run_one(input string req);
    pulse_start();
    chk(busy == 1'b1 && done == 1'b0, "R2", {busy, done}, 2);
    wait_done(req);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(pass == 1'b0, "R1 pass", pass, 0);
    chk(ext_count == '0, "R1 count", ext_count, 0);
  endtask

  task automatic t_equal_freq();
    set_all(16'd20, 16'd15, 16'd25);
    run_one("R3 done");
    chk(ext_count == 16'd20, "R3 count", ext_count, 20);
    chk(pass == 1'b1, "R5 pass mid", pass, 1);
    chk(busy == 1'b0, "R6 busy low", busy, 0);
    repeat (30) @(negedge clk);
    chk(done == 1'b1, "R6 done held", done, 1);
    write_reg(0, 16'd0);
    run_one("R3 zero end");
    chk(ext_count == 16'd1, "R3 end 0 as 1", ext_count, 1);
    write_reg(0, 16'd20);
  endtask

  task automatic t_inclusive();
    set_all(16'd20, 16'd20, 16'd20);
    run_one("R5 done");
    chk(pass == 1'b1, "R5 lo=hi=count", pass, 1);
    set_all(16'd20, 16'd21, 16'd30);
    run_one("R5 done");
    chk(pass == 1'b0, "R5 below lo", pass, 0);
    set_all(16'd20, 16'd0, 16'd19);
    run_one("R5 done");
    chk(pass == 1'b0, "R5 above hi", pass, 0);
  endtask

  task automatic t_buffering();
    set_all(16'd20, 16'd15, 16'd25);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R2 busy", busy, 1);
    write_reg(0, 16'd5);
    write_reg(2, 16'd3);
    pulse_start();
    wait_done("R7 done");
    chk(ext_count == 16'd20, "R2 R7 count kept", ext_count, 20);
    chk(pass == 1'b1, "R7 limits kept", pass, 1);
    run_one("R7 done next");
    chk(ext_count == 16'd5, "R7 new end", ext_count, 5);
    chk(pass == 1'b0, "R7 new hi", pass, 0);
  endtask

  task automatic t_clear();
    pulse_clear();
    chk(done == 1'b0 && pass == 1'b0 && ext_count == '0, "R9 clear", {done, pass, ext_count}, 0);
    set_all(16'd20, 16'd15, 16'd25);
    pulse_start();
    repeat (50) @(negedge clk);
    pulse_clear();
    repeat (1500) @(negedge clk);
    chk(busy == 1'b0, "R9 busy falls", busy, 0);
    chk(done == 1'b0, "R9 result discarded", done, 0);
  endtask

  task automatic t_freq_scale();
    ext_half = 40.0;
    repeat (100) @(negedge clk);
    set_all(16'd20, 16'd20, 16'd30);
    run_one("R4 done fast");
    chk(ext_count >= 16'd24 && ext_count <= 16'd26, "R4 fast count", ext_count, 25);
    chk(pass == 1'b1, "R5 fast pass", pass, 1);
    ext_half = 62.5;
    repeat (100) @(negedge clk);
    run_one("R4 done slow");
    chk(ext_count >= 16'd15 && ext_count <= 16'd17, "R4 slow count", ext_count, 16);
    chk(pass == 1'b0, "R5 slow fail", pass, 0);
  endtask

  task automatic t_ref_mux();
    ref_sel = 1'b0;
    @(posedge clk_loc); #10;
    chk(ref_out == 1'b1, "R10 loc high", ref_out, 1);
    @(negedge clk_loc); #10;
    chk(ref_out == 1'b0, "R10 loc low", ref_out, 0);
    ref_sel = 1'b1;
    @(posedge clk_ext); #10;
    chk(ref_out == 1'b1, "R10 ext high", ref_out, 1);
    @(negedge clk_ext); #10;
    chk(ref_out == 1'b0, "R10 ext low", ref_out, 0);
  endtask

  task automatic t_ext_absent();
    ext_en = 1'b0;
    set_all(16'd20, 16'd0, 16'hFFFF);
    run_one("R8 done");
    chk(ext_count == '0, "R8 count zero", ext_count, 0);
    chk(pass == 1'b0, "R8 fail", pass, 0);
    chk(done == 1'b1, "R8 done", done, 1);
  endtask

  initial begin
    rst_n = 1'b0; ref_sel = 1'b0; wr_data = '0;
    wr_end = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; start = 1'b0; clear = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    t_reset();
    t_equal_freq();
    t_inclusive();
    t_buffering();
    t_clear();
    t_freq_scale();
    t_ref_mux();
    t_ext_absent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule